// File: doc/BRIEF.md
# Spectrum Magnitude Estimator

This block turns the complex output of a radix-2 transform, one bin per transfer in bin order, into an 8-bit magnitude code for each bin. It does not compute a square root. It takes the absolute value of the real and imaginary parts, keeps the top four magnitude bits of each, and uses the two nibbles as row and column of a 16×16 table of magnitude codes. The table is computed when the design is elaborated.

A real input signal gives a spectrum that mirrors itself about the midpoint. For that reason only bins 0 through N/2 produce a result. The upper bins are still accepted at the input, but nothing is sent out for them. At the two end bins, 0 and N/2, the imaginary part is known to be zero, so the column index is forced to zero there. Results leave through a valid/ready stream. Each result carries its bin number, and a last flag marks bin N/2. The block's internal bin count advances by one on every accepted input and wraps after N inputs, so frames can follow each other without a gap.

Top module: `spec_mag_est`

## Requirements
- R1: The real and imaginary parts are each replaced by their absolute value before any index is taken, so a negative part yields the same index as its positive counterpart.
- R2: Each table index is bits 14 down to 11 of the 16-bit absolute value, which is the absolute value shifted right by 11. The row index comes from the real part and the column index from the imaginary part.
- R3: The absolute value of -32768 saturates to 32767 and therefore gives index 15.
- R4: The table entry at row r, column c is min(255, round(16·sqrt(r²+c²))). Row 0 reads 16·c, and the entry at row 15, column 15 is 255.
- R5: For bins 0 and N/2 (N/2 = 128 by default) the imaginary input is ignored and the column index is 0.
- R6: Bins N/2+1 through N-1 are accepted at the input, and no result is produced for them.
- R7: Results come out in increasing bin order from 0 to N/2. out_bin carries the bin number, out_last is high only at bin N/2, and the input that follows bin N-1 is bin 0 of the next frame.
- R8: A result is valid on the clock edge that follows the input handshake of its bin.
- R9: While out_valid is high and out_ready is low, the output holds its magnitude, bin and last flag unchanged, and in_ready is low. In every other cycle in_ready is high.
- R10: After reset, out_valid is 0, in_ready is 1, out_mag, out_bin and out_last are 0, and the next input accepted is bin 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | An input bin is offered |
| in_ready | output | 1 | The block can take an input bin |
| in_re | input | 16 | Real part of the bin, signed Q8.7 |
| in_im | input | 16 | Imaginary part of the bin, signed Q8.7 |
| out_valid | output | 1 | A magnitude result is offered |
| out_ready | input | 1 | The consumer takes the result |
| out_mag | output | 8 | Magnitude code read from the table |
| out_bin | output | 8 | Bin number of the result |
| out_last | output | 1 | High when the result belongs to bin N/2 |

## Verification
A result is due exactly one rising edge after its input handshake. The bench changes its inputs on the falling edge. It checks out_valid, out_bin, out_last and out_mag on the next falling edge, which comes after that single register stage. For a skipped upper bin, the same falling edge must show out_valid low. During a stall, each falling edge is checked for an unchanged result and a low in_ready. After the stall is released, the next falling edge must show the following bin, which was taken on the same edge that drained the held result.

// File: rtl/mag_est_pkg.sv
package mag_est_pkg;

   // Integer square root, rounded down, computed bit by bit
   function automatic int unsigned isqrt(input int unsigned v);
      int unsigned res;
      int unsigned rem;
      int unsigned bitv;
      res  = 0;
      rem  = v;
      bitv = 32'h4000_0000;
      while (bitv > rem) bitv = bitv >> 2;
      while (bitv != 0) begin
         if (rem >= res + bitv) begin
            rem = rem - (res + bitv);
            res = (res >> 1) + bitv;
         end else begin
            res = res >> 1;
         end
         bitv = bitv >> 2;
      end
      return res;
   endfunction

   // Table entry: round(2^(mag_w-idx_w) * sqrt(r^2 + c^2)), clipped to the code range
   function automatic int unsigned lut_value(input int unsigned r, input int unsigned c,
                                             input int unsigned idx_w, input int unsigned mag_w);
      int unsigned scale;
      int unsigned twice;
      int unsigned v;
      int unsigned top;
      scale = 32'd1 << (mag_w - idx_w);
      twice = isqrt(4 * scale * scale * (r * r + c * c));
      v     = (twice + 1) >> 1;
      top   = (32'd1 << mag_w) - 1;
      if (v > top) v = top;
      return v;
   endfunction

endpackage

// File: rtl/mag_abs_nibble.sv
module mag_abs_nibble #(
   parameter int DATA_W = 16,
   parameter int IDX_W  = 4
) (
   input  logic [DATA_W-1:0] val,
   output logic [IDX_W-1:0]  nib
);
   localparam int MAG_W = DATA_W - 1;

   logic [MAG_W-1:0] mag;
   logic             unused_low;

   always_comb begin
      if (!val[DATA_W-1]) begin
         mag = val[MAG_W-1:0];
      end else if (val[MAG_W-1:0] == '0) begin
         mag = '1;                               // most negative value clips
      end else begin
         mag = (~val[MAG_W-1:0]) + 1'b1;
      end
   end

   assign nib        = mag[MAG_W-1 -: IDX_W];
   assign unused_low = ^mag[MAG_W-IDX_W-1:0];
endmodule

// File: rtl/mag_lut_rom.sv
module mag_lut_rom #(
   parameter int IDX_W = 4,
   parameter int MAG_W = 8
) (
   input  logic [IDX_W-1:0] row,
   input  logic [IDX_W-1:0] col,
   output logic [MAG_W-1:0] mag
);
   localparam int SIDE = 1 << IDX_W;

   logic [MAG_W-1:0] rom [SIDE][SIDE];

   for (genvar r = 0; r < SIDE; r++) begin : g_row
      for (genvar c = 0; c < SIDE; c++) begin : g_col
         assign rom[r][c] = MAG_W'(mag_est_pkg::lut_value(r, c, IDX_W, MAG_W));
      end
   end

   assign mag = rom[row][col];
endmodule

// File: rtl/mag_bin_seq.sv
module mag_bin_seq #(
   parameter int N_POINTS = 256
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        step,
   output logic [$clog2(N_POINTS)-1:0] bin,
   output logic                        emit,
   output logic                        edge_bin,
   output logic                        last
);
   localparam int              BIN_W = $clog2(N_POINTS);
   localparam logic [BIN_W-1:0] HALF = BIN_W'(N_POINTS / 2);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bin <= '0;
      end else if (step) begin
         bin <= bin + 1'b1;                       // wraps at N_POINTS
      end
   end

   assign emit     = (bin <= HALF);
   assign last     = (bin == HALF);
   assign edge_bin = (bin == '0) || last;
endmodule

// File: rtl/spec_mag_est.sv
module spec_mag_est #(
   parameter int N_POINTS = 256,
   parameter int DATA_W   = 16,
   parameter int IDX_W    = 4,
   parameter int MAG_W    = 8
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        in_valid,
   output logic                        in_ready,
   input  logic [DATA_W-1:0]           in_re,
   input  logic [DATA_W-1:0]           in_im,
   output logic                        out_valid,
   input  logic                        out_ready,
   output logic [MAG_W-1:0]            out_mag,
   output logic [$clog2(N_POINTS)-1:0] out_bin,
   output logic                        out_last
);
   localparam int BIN_W = $clog2(N_POINTS);

   if ((N_POINTS < 4) || ((N_POINTS & (N_POINTS - 1)) != 0)) begin : g_bad_points
      $error("N_POINTS must be a power of two of at least 4");
   end
   if (DATA_W <= IDX_W + 1) begin : g_bad_width
      $error("DATA_W must exceed IDX_W + 1");
   end
   if (MAG_W < IDX_W) begin : g_bad_mag
      $error("MAG_W must be at least IDX_W");
   end

   logic              accept;
   logic [BIN_W-1:0]  bin;
   logic              emit;
   logic              edge_bin;
   logic              last;
   logic [IDX_W-1:0]  row;
   logic [IDX_W-1:0]  col_raw;
   logic [IDX_W-1:0]  col;
   logic [MAG_W-1:0]  lut_mag;

   assign in_ready = !out_valid || out_ready;
   assign accept   = in_valid && in_ready;

   mag_bin_seq #(.N_POINTS(N_POINTS)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .step     (accept),
      .bin      (bin),
      .emit     (emit),
      .edge_bin (edge_bin),
      .last     (last)
   );

   mag_abs_nibble #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_abs_re (
      .val (in_re),
      .nib (row)
   );

   mag_abs_nibble #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_abs_im (
      .val (in_im),
      .nib (col_raw)
   );

   assign col = edge_bin ? '0 : col_raw;

   mag_lut_rom #(.IDX_W(IDX_W), .MAG_W(MAG_W)) u_rom (
      .row (row),
      .col (col),
      .mag (lut_mag)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_mag   <= '0;
         out_bin   <= '0;
         out_last  <= 1'b0;
      end else if (accept) begin
         out_valid <= emit;
         if (emit) begin
            out_mag  <= lut_mag;
            out_bin  <= bin;
            out_last <= last;
         end
      end else if (out_ready) begin
         out_valid <= 1'b0;
      end
   end
endmodule

// File: rtl/spec_mag_est_chk.sv
module spec_mag_est_chk #(
   parameter int N_POINTS = 256,
   parameter int MAG_W    = 8
) (
   input logic                        clk,
   input logic                        rst_n,
   input logic                        in_valid,
   input logic                        in_ready,
   input logic                        out_valid,
   input logic                        out_ready,
   input logic [MAG_W-1:0]            out_mag,
   input logic [$clog2(N_POINTS)-1:0] out_bin,
   input logic                        out_last
);
   localparam int               BIN_W = $clog2(N_POINTS);
   localparam logic [BIN_W-1:0] HALF  = BIN_W'(N_POINTS / 2);

   logic              acc;
   logic [BIN_W-1:0]  ck_bin;
   logic [BIN_W-1:0]  exp_next;
   logic              seen;

   assign acc = in_valid && in_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ck_bin   <= '0;
         exp_next <= '0;
         seen     <= 1'b0;
      end else begin
         if (acc) ck_bin <= ck_bin + 1'b1;
         if (out_valid && out_ready) begin
            seen     <= 1'b1;
            exp_next <= out_last ? '0 : out_bin + 1'b1;
         end
      end
   end

   // R7: output bins never exceed the midpoint, last only at the midpoint
   p_bin_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_bin <= HALF));
   p_last_mid_r7: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_last == (out_bin == HALF)));
   // R7: consecutive results follow bin order
   p_order_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && seen) |-> (out_bin == exp_next));
   // R8: a lower-half bin shows up one edge after its handshake
   p_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && (ck_bin <= HALF)) |=> (out_valid && (out_bin == $past(ck_bin))));
   // R6: an upper-half bin leaves no result
   p_skip_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && (ck_bin > HALF)) |=> !out_valid);
   // R9: a stalled result holds still and blocks the input
   p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_mag) && $stable(out_bin) && $stable(out_last)));
   p_block_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |-> !in_ready);
endmodule

bind spec_mag_est spec_mag_est_chk #(.N_POINTS(N_POINTS), .MAG_W(MAG_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .in_ready  (in_ready),
   .out_valid (out_valid),
   .out_ready (out_ready),
   .out_mag   (out_mag),
   .out_bin   (out_bin),
   .out_last  (out_last)
);

// File: tb/spec_mag_est_test.sv
module spec_mag_est_test;
   localparam int CLK_PERIOD = 10;
   localparam int NPTS = 256;
   localparam int HALF = NPTS / 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic        in_ready;
   logic [15:0] in_re = '0;
   logic [15:0] in_im = '0;
   logic        out_valid;
   logic        out_ready = 1'b1;
   logic [7:0]  out_mag;
   logic [7:0]  out_bin;
   logic        out_last;

   int checks = 0;
   int fails  = 0;
   int bench_bin = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   spec_mag_est uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_re(in_re), .in_im(in_im), .out_valid(out_valid), .out_ready(out_ready),
      .out_mag(out_mag), .out_bin(out_bin), .out_last(out_last)
   );

   task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   function automatic int ref_mag(input int re, input int im, input int b);
      int  ar;
      int  ai;
      int  r;
      int  c;
      int  m;
      real v;
      ar = (re < 0) ? ((re == -32768) ? 32767 : -re) : re;
      ai = (im < 0) ? ((im == -32768) ? 32767 : -im) : im;
      r = ar / 2048;
      c = ai / 2048;
      if (b == 0 || b == HALF) c = 0;
      v = 16.0 * $sqrt(real'(r * r + c * c));
      m = $rtoi(v + 0.5);
      if (m > 255) m = 255;
      return m;
   endfunction

   function automatic void gen(input int mode, input int b, output int re, output int im);
      case (mode)
         1: begin
            re = -((b % 16) * 2048 + 1);
            im = -(((b * 7) % 16) * 2048 + 5);
         end
         2: begin
            re = (b % 16) * 2048 + ((b % 2 != 0) ? 2047 : 0);
            im = ((b / 16) % 16) * 2048 + ((b % 3 == 0) ? 2047 : 0);
         end
         3: begin
            if (b % 3 == 0) begin
               re = -32768;
               im = (b % 2 != 0) ? -32768 : 1000;
            end else begin
               re = b * 100;
               im = -32768;
            end
         end
         default: begin
            if (b == 5) begin
               re = 32767;
               im = 32767;
            end else begin
               re = ((b * 2741 + mode * 5003) % 65536) - 32768;
               im = ((b * 6133 + 777) % 65536) - 32768;
            end
         end
      endcase
   endfunction

   // one input bin, result checked one edge later (R8)
   task automatic push(input int re, input int im, input string tag);
      int b;
      int e;
      b = bench_bin;
      e = ref_mag(re, im, b);
      @(negedge clk);
      chk(in_ready == 1'b1, "R9", "in_ready while output free", int'(in_ready), 1);
      in_valid = 1'b1;
      in_re = 16'(re);
      in_im = 16'(im);
      @(negedge clk);
      in_valid = 1'b0;
      if (b <= HALF) begin
         chk(out_valid == 1'b1, "R8", "out_valid one edge after handshake", int'(out_valid), 1);
         chk(int'(out_bin) == b, "R7", "out_bin", int'(out_bin), b);
         chk(out_last == (b == HALF), "R7", "out_last", int'(out_last), int'(b == HALF));
         chk(int'(out_mag) == e, tag, "out_mag", int'(out_mag), e);
      end else begin
         chk(out_valid == 1'b0, "R6", "no result for upper bin", int'(out_valid), 0);
      end
      bench_bin = (b + 1) % NPTS;
   endtask

   task automatic run_bins(input int mode, input int first, input string tag);
      int re;
      int im;
      for (int b = first; b < NPTS; b++) begin
         gen(mode, b, re, im);
         if (b == 0 || b == HALF) push(re, im, "R5");
         else push(re, im, tag);
      end
   endtask

   task automatic t_reset;
      chk(out_valid == 1'b0, "R10", "out_valid in reset", int'(out_valid), 0);
      chk(in_ready == 1'b1, "R10", "in_ready in reset", int'(in_ready), 1);
      chk(out_mag == 8'd0 && out_bin == 8'd0 && out_last == 1'b0, "R10", "outputs zero in reset",
          int'(out_mag) + int'(out_bin) + int'(out_last), 0);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic t_general;   run_bins(0, 0, "R4"); endtask
   task automatic t_negative;  run_bins(1, 0, "R1"); endtask
   task automatic t_boundary;  run_bins(2, 0, "R2"); endtask
   task automatic t_saturate;  run_bins(3, 0, "R3"); endtask

   task automatic t_corner;
      // R4: row 0 gives 16*c, corner 15/15 gives 255 (bin 5 of mode 0 frame already), check directly too
      chk(ref_mag(0, 7 * 2048, 1) == 112, "R4", "model row 0 col 7", ref_mag(0, 7 * 2048, 1), 112);
      run_bins(0, 0, "R4");
   endtask

   task automatic t_backpressure;
      int re0, im0, re1, im1, e0, e1;
      gen(0, 0, re0, im0);
      gen(0, 1, re1, im1);
      e0 = ref_mag(re0, im0, 0);
      e1 = ref_mag(re1, im1, 1);
      @(negedge clk);
      out_ready = 1'b0;
      in_valid = 1'b1;
      in_re = 16'(re0);
      in_im = 16'(im0);
      @(negedge clk);
      in_re = 16'(re1);
      in_im = 16'(im1);
      chk(in_ready == 1'b0, "R9", "in_ready low while stalled", int'(in_ready), 0);
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         chk(out_valid == 1'b1, "R9", "held out_valid", int'(out_valid), 1);
         chk(out_bin == 8'd0, "R9", "held out_bin", int'(out_bin), 0);
         chk(int'(out_mag) == e0, "R9", "held out_mag", int'(out_mag), e0);
         chk(in_ready == 1'b0, "R9", "in_ready low while stalled", int'(in_ready), 0);
      end
      out_ready = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      chk(out_valid == 1'b1 && out_bin == 8'd1, "R9", "next bin after release", int'(out_bin), 1);
      chk(int'(out_mag) == e1, "R9", "mag after release", int'(out_mag), e1);
      bench_bin = 2;
      run_bins(0, 2, "R4");
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      t_general();
      t_negative();
      t_boundary();
      t_saturate();
      t_corner();
      t_backpressure();
      t_general();
      repeat (2) @(negedge clk);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule